// File: doc/BRIEF.md
# Gated Frequency-Shift Metal Detector

This block decides whether metal lies under a sensing coil. It does this by measuring the frequency of a square wave from an oscillator-and-comparator front end. A nearby metal object detunes the coil, so the oscillator frequency moves away from its undisturbed value.

A timer on the system clock opens a measurement window of a fixed number of clock cycles. While the window is open, a second counter counts rising edges of the sensor wave. That wave is brought into the clock domain through a synchronizer, so nothing is ever clocked by the sensor itself. When the window closes, the edge total is latched. It is compared with a programmed nominal total, and a metal flag is set if the two differ by more than a tolerance. A one-cycle clear strobe then zeroes both counters and the next window begins.

The controller is a four-state machine:
- `ST_IDLE` is held during reset.
- The *start* transition goes from `ST_IDLE` to `ST_GATE` on the first clock after reset is released.
- `ST_GATE` loops on itself until the timer reports its last cycle. The *gate_done* transition then goes to `ST_LATCH`, where the result is registered.
- The *latch_done* transition goes to `ST_FLUSH`, the clear cycle.
- The *restart* transition goes from `ST_FLUSH` back to `ST_GATE`.

Top module: `gated_freq_metal_det`

## Requirements
- R1: While `rst` is high at a clock edge, `metal_o` is 0, `edge_cnt_o` is 0 and `cnt_clr_o` is 0. The first window opens on the first clock edge after `rst` is released. The first clear strobe is therefore seen in the (GATE_LEN+2)-th clock cycle after release.
- R2: A window lasts exactly GATE_LEN clock cycles. It is followed by one latch cycle and one clear cycle, so consecutive clear strobes are GATE_LEN+2 cycles apart.
- R3: `cnt_clr_o` is high for exactly one clock cycle, the cycle directly after the latch cycle.
- R4: `sense_in` passes through a two-flop synchronizer. Each 0-to-1 transition of the synchronized sample that falls inside a window adds one to the edge count.
- R5: `edge_cnt_o` shows the edge total of the most recently closed window. It updates at the end of the latch cycle and holds until the next latch.
- R6: `metal_o` becomes 1 when |edge total - NOMINAL| > THRESH, and 0 otherwise. A difference of exactly THRESH gives 0.
- R7: `metal_o` holds its value from one latch cycle to the next.
- R8: The edge counter saturates at 2^CNT_W-1 instead of wrapping.
- R9: The clear strobe zeroes both counters, so no count carries from one window into the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sense_in | input | 1 | Square wave from the oscillator comparator (asynchronous) |
| metal_o | output | 1 | Metal-present flag, registered once per window |
| cnt_clr_o | output | 1 | One-cycle strobe that clears both counters |
| edge_cnt_o | output | CNT_W | Edge total latched from the last window |

## Verification
The sensor wave is driven with a known number of pulses placed inside each window. The totals sit on both sides of the tolerance edge: nominal, nominal plus and minus THRESH, and one count beyond each of those. This separates a strict from a non-strict comparison and catches a sign error in the difference. A large total followed by a nominal one shows that counts do not carry between windows. Windows with no pulses and a mid-window reset pin down the start-up behaviour. On a narrow-counter variant, a run of fast toggles overflows the counter; a wrapping counter would land back inside the tolerance, while a saturating one reports metal.

// File: rtl/mdet_pkg.sv
package mdet_pkg;

    // Controller states for the measurement sequence
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GATE  = 2'd1,
        ST_LATCH = 2'd2,
        ST_FLUSH = 2'd3
    } mdet_state_e;

endpackage

// File: rtl/mdet_sync_edge.sv
module mdet_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[0] <= 1'b0;
                    else     chain_q[0] <= async_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= 1'b0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= chain_q[STAGES-1];
    end

    assign rise_o = chain_q[STAGES-1] & ~prev_q;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rise_o |=> !rise_o); // R4

endmodule

// File: rtl/mdet_gate_timer.sv
module mdet_gate_timer #(
    parameter int REF_W    = 11,
    parameter int GATE_LEN = 2000
) (
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic run_i,
    output logic last_o
);

    localparam logic [REF_W-1:0] LAST_V = REF_W'(GATE_LEN - 1);

    logic [REF_W-1:0] ref_q;
    logic             at_last;

    assign at_last = (ref_q == LAST_V);
    assign last_o  = run_i & at_last;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            ref_q <= '0;
        end else if (run_i && !at_last) begin
            ref_q <= ref_q + 1'b1;
        end
    end

    AST_REF_BOUND: assert property (@(posedge clk) disable iff (rst)
        ref_q <= LAST_V); // R2
    AST_LAST_ONCE: assert property (@(posedge clk) disable iff (rst)
        last_o |=> !last_o); // R2

endmodule

// File: rtl/mdet_edge_counter.sv
module mdet_edge_counter #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != MAX_V)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == MAX_V && !clr_i) |=> (cnt_q == MAX_V)); // R8
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> (cnt_q >= $past(cnt_q))); // R8
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (cnt_q == '0)); // R9

endmodule

// File: rtl/mdet_ctrl.sv
module mdet_ctrl
    import mdet_pkg::*;
#(
    parameter int CNT_W   = 11,
    parameter int NOMINAL = 1000,
    parameter int THRESH  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_last_i,
    input  logic [CNT_W-1:0] edge_cnt_i,
    output logic             run_o,
    output logic             clr_o,
    output logic             metal_o,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] NOM_V = CNT_W'(NOMINAL);
    localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

    mdet_state_e state_q, state_d;
    logic [CNT_W-1:0] diff;
    logic             shifted;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Transitions: start, gate_done, latch_done, restart
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = ST_GATE;
            ST_GATE:  if (gate_last_i) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_GATE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Tolerance comparison
    always_comb begin
        if (edge_cnt_i >= NOM_V) diff = edge_cnt_i - NOM_V;
        else                     diff = NOM_V - edge_cnt_i;
        shifted = (diff > THR_V);
    end

    // Outputs
    assign run_o = (state_q == ST_GATE);
    assign clr_o = (state_q == ST_FLUSH);

    always_ff @(posedge clk) begin
        if (rst) begin
            metal_o <= 1'b0;
            cnt_o   <= '0;
        end else if (state_q == ST_LATCH) begin
            metal_o <= shifted;
            cnt_o   <= edge_cnt_i;
        end
    end

    AST_CLR_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        clr_o |=> !clr_o); // R3
    AST_CLR_AFTER_LATCH: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LATCH) |=> clr_o); // R3
    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_LATCH) |=> ($stable(metal_o) && $stable(cnt_o))); // R7
    AST_START_GATE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE) |=> (state_q == ST_GATE)); // R1

endmodule

// File: rtl/gated_freq_metal_det.sv
module gated_freq_metal_det #(
    parameter int CNT_W       = 11,
    parameter int REF_W       = 11,
    parameter int GATE_LEN    = 2000,
    parameter int NOMINAL     = 1000,
    parameter int THRESH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sense_in,
    output logic             metal_o,
    output logic             cnt_clr_o,
    output logic [CNT_W-1:0] edge_cnt_o
);

    logic             rise;
    logic             run;
    logic             clr;
    logic             gate_last;
    logic [CNT_W-1:0] live_cnt;

    mdet_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (sense_in),
        .rise_o  (rise)
    );

    mdet_gate_timer #(.REF_W(REF_W), .GATE_LEN(GATE_LEN)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr),
        .run_i  (run),
        .last_o (gate_last)
    );

    mdet_edge_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .clr_i (clr),
        .inc_i (rise & run),
        .cnt_o (live_cnt)
    );

    mdet_ctrl #(.CNT_W(CNT_W), .NOMINAL(NOMINAL), .THRESH(THRESH)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .gate_last_i (gate_last),
        .edge_cnt_i  (live_cnt),
        .run_o       (run),
        .clr_o       (clr),
        .metal_o     (metal_o),
        .cnt_o       (edge_cnt_o)
    );

    assign cnt_clr_o = clr;

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> (!metal_o && !cnt_clr_o && edge_cnt_o == '0)); // R1

endmodule

// File: tb/tb_gated_freq_metal_det.sv
module tb_gated_freq_metal_det;

    localparam int GATE = 128;
    localparam int NOM  = 10;
    localparam int THR  = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sense = 1'b0;
    logic        sense_s = 1'b0;
    logic        metal, clr, metal_s, clr_s;
    logic [10:0] cnt;
    logic [4:0]  cnt_s;

    int total = 0;
    int fails = 0;
    logic prev_metal = 1'b0;
    int   prev_cnt = 0;

    always #10 clk = ~clk;

    gated_freq_metal_det #(.CNT_W(11), .REF_W(11), .GATE_LEN(GATE),
        .NOMINAL(NOM), .THRESH(THR)) dut (
        .clk(clk), .rst(rst), .sense_in(sense),
        .metal_o(metal), .cnt_clr_o(clr), .edge_cnt_o(cnt));

    gated_freq_metal_det #(.CNT_W(5), .REF_W(8), .GATE_LEN(GATE),
        .NOMINAL(20), .THRESH(THR)) dut_sat (
        .clk(clk), .rst(rst), .sense_in(sense_s),
        .metal_o(metal_s), .cnt_clr_o(clr_s), .edge_cnt_o(cnt_s));

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // R1: reset state and first window timing
    task automatic t_reset();
        int cyc;
        rst = 1'b1;
        sense = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 metal in reset", int'(metal), 0);
        check("R1 count in reset", int'(cnt), 0);
        check("R1 clr in reset", int'(clr), 0);
        rst = 1'b0;
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!clr && cyc < 1000);
        check("R1 first strobe cycle", cyc, GATE + 2);
        check("R6 empty window count", int'(cnt), 0);
        check("R6 empty window metal", int'(metal), 1);
        prev_metal = metal;
        prev_cnt = cnt;
    endtask

    // One window with n pulses; starts and ends on a clear-strobe cycle
    task automatic t_window(int n);
        int cyc;
        int d;
        int exp_m;
        cyc = 0;
        sense = 1'b0;
        @(negedge clk); cyc++;
        check("R3 strobe one cycle", int'(clr), 0);
        @(negedge clk); cyc++;
        check("R7 metal held mid window", int'(metal), int'(prev_metal));
        check("R5 count held mid window", int'(cnt), prev_cnt);
        for (int i = 0; i < n; i++) begin
            sense = 1'b1;
            repeat (2) begin @(negedge clk); cyc++; end
            sense = 1'b0;
            repeat (2) begin @(negedge clk); cyc++; end
        end
        while (!clr && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        check("R2 strobe spacing", cyc, GATE + 2);
        check("R4 R9 edge total", int'(cnt), n);
        d = (n > NOM) ? n - NOM : NOM - n;
        exp_m = (d > THR) ? 1 : 0;
        check("R6 metal flag", int'(metal), exp_m);
        prev_metal = metal;
        prev_cnt = cnt;
    endtask

    // R8: overflow on the narrow counter
    task automatic t_saturate();
        int cyc;
        cyc = 0;
        while (!clr_s && cyc < 1000) begin @(negedge clk); cyc++; end
        for (int i = 0; i < 100; i++) begin
            sense_s = ~sense_s;
            @(negedge clk);
        end
        sense_s = 1'b0;
        cyc = 0;
        do begin @(negedge clk); cyc++; end while (!clr_s && cyc < 1000);
        check("R8 saturated count", int'(cnt_s), 31);
        check("R8 saturated metal", int'(metal_s), 1);
    endtask

    // R1: reset in the middle of a window
    task automatic t_mid_reset();
        repeat (3) @(negedge clk);
        for (int i = 0; i < 5; i++) begin
            sense = 1'b1; repeat (2) @(negedge clk);
            sense = 1'b0; repeat (2) @(negedge clk);
        end
        t_reset();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_window(NOM);          // R6 exact nominal
        t_window(NOM + THR);    // R6 at upper edge
        t_window(NOM + THR + 1);// R6 beyond upper edge
        t_window(NOM - THR);    // R6 at lower edge
        t_window(NOM - THR - 1);// R6 beyond lower edge
        t_window(30);           // R4 large total
        t_window(NOM);          // R9 no carry-over
        t_mid_reset();
        t_window(NOM + 1);
        t_saturate();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule